// File: doc/BRIEF.md
# Clock-Synchronous Serial Transceiver

This block moves one 8-bit word at a time over a three-wire synchronous serial link: a shift clock, a data line in each direction, and a ready line for handshaking. A parallel host side loads the word into a shift register and reads the result back. The same register sends its contents least significant bit first and, in the same transfer, fills with the bits that arrive. Incoming data is captured on the rising edge of the shift clock. Outgoing data changes on the falling edge.

In master mode the block makes the shift clock itself by dividing the system clock. It runs the clock only for the eight cycles of a word, and only after the partner has pulled the active-low ready line down. In slave mode the shift clock, the data input and the ready input come from outside and pass through two-flop synchronizers. The slave pulls its ready output low from its start command until its eighth received clock. The slave never gates the external clock: every edge that arrives shifts the register, including edges after the eighth. A done flag is cleared by each start command and set after the eighth rising edge counted from that command. The host can poll the flag or clear it. For continuous transfers, reload the register and issue a new start after each completion.

The controller has three states:
- `ST_IDLE`: the register accepts parallel writes. On `start`, a master moves to `ST_WAIT` and a slave moves to `ST_SHIFT`.
- `ST_WAIT`: a master waits here. It moves to `ST_SHIFT` when the synchronized ready input is low.
- `ST_SHIFT`: the word is shifted. The state returns to `ST_IDLE` on the eighth rising shift-clock edge.

Top module: `sio_unit`

## Requirements
- R1: On each rising shift-clock edge the register shifts right by one and takes the input bit into bit 7. After eight edges the first bit received sits in bit 0 and the last in bit 7.
- R2: The serial output changes only on a falling shift-clock edge. Each falling edge drives the current register bit 0, so bit 0 of the loaded word goes out first. Before the first falling edge of a transfer the output keeps the last bit sent in the previous transfer.
- R3: A start command accepted in `ST_IDLE` clears `done`. `done` becomes 1 on the eighth rising shift-clock edge counted from that command.
- R4: In master mode `sck_out` idles at 1. While shifting it stays low for H system clocks and high for H system clocks, where H = max(`half_div`, 2). It stops high after exactly eight falling edges.
- R5: In slave mode every synchronized external clock edge shifts the register, even after `done` is set. `done` stays 1 while further edges arrive.
- R6: A slave drives `rdy_out` low (0 = ready to receive) from its accepted start until its eighth rising edge, and drives it high otherwise. A master issues no shift-clock edge while its synchronized `rdy_in` is high.
- R7: A write with `wr_en` is taken only in `ST_IDLE`. A write in `ST_WAIT` or `ST_SHIFT` is ignored. `rd_data` always shows the live register, including partial contents during a transfer.
- R8: `done_clr` sets `done` to 0 when no transfer is completing in that cycle.
- R9: After reset `done` = 0, `rdy_out` = 1, `sck_out` = 1, `sdo` = 1 and `rd_data` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_mode | input | 1 | 1 = internal divided clock, 0 = external clock |
| half_div | input | DIV_W | Half period of the shift clock in system clocks (values below 2 act as 2) |
| wr_en | input | 1 | Parallel load strobe |
| wr_data | input | WORD_W | Parallel load value |
| rd_data | output | WORD_W | Live shift register contents |
| start | input | 1 | Start command |
| done_clr | input | 1 | Clears the done flag |
| done | output | 1 | Transfer-complete flag |
| sck_in | input | 1 | External shift clock (slave) |
| sck_out | output | 1 | Generated shift clock (master) |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| rdy_in | input | 1 | Partner ready, active low (master) |
| rdy_out | output | 1 | Own ready, active low (slave) |

## Verification
The assertions assume that `master_mode` stays constant while a transfer is open. They also assume that each external clock level lasts at least two system clocks, so that the synchronizer sees every edge. The stimulus sets the mode once per instance. It drives the external clock with phases of six system clocks. In loopback the master half period is eight, which covers the synchronizer delays of both partners. The one run with the clamped divider checks only clock timing and ignores the data.

// File: rtl/sio_pkg.sv
package sio_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_SHIFT = 2'd2
    } sio_state_t;
endpackage

// File: rtl/sio_sync.sv
module sio_sync #(
    parameter int          W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/sio_clkgen.sv
module sio_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half,
    output logic             sck,
    output logic             fall_p,
    output logic             rise_p
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] half_eff;
    logic             term;

    always_comb begin
        half_eff = (half < DIV_W'(2)) ? DIV_W'(2) : half;
        term     = run && (cnt == half_eff - DIV_W'(1));
        fall_p   = term && sck;
        rise_p   = term && !sck;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            sck <= 1'b1;
        end else if (!run) begin
            cnt <= '0;
            sck <= 1'b1;
        end else if (term) begin
            cnt <= '0;
            sck <= ~sck;
        end else begin
            cnt <= cnt + DIV_W'(1);
        end
    end

    // R4: the phase counter never runs past the half period
    assert_phase_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < half_eff);
endmodule

// File: rtl/sio_shifter.sv
module sio_shifter #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] load_val,
    input  logic              rise_evt,
    input  logic              fall_evt,
    input  logic              bit_in,
    output logic [WORD_W-1:0] sr,
    output logic              sdo_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr <= '0;
        end else if (load) begin
            sr <= load_val;
        end else if (rise_evt) begin
            sr <= {bit_in, sr[WORD_W-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sdo_q <= 1'b1;
        end else if (fall_evt) begin
            sdo_q <= sr[0];
        end
    end

    // R1: a rising edge without a load takes the input bit into the top position
    assert_top_bit_taken_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_evt && !load) |=> (sr[WORD_W-1] == $past(bit_in)));
endmodule

// File: rtl/sio_unit.sv
module sio_unit #(
    parameter int WORD_W = 8,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master_mode,
    input  logic [DIV_W-1:0]  half_div,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] rd_data,
    input  logic              start,
    input  logic              done_clr,
    output logic              done,
    input  logic              sck_in,
    output logic              sck_out,
    input  logic              sdi,
    output logic              sdo,
    input  logic              rdy_in,
    output logic              rdy_out
);
    import sio_pkg::*;

    localparam int CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

    sio_state_t state, state_nx;

    logic             sck_s, sdi_s, rdy_s;
    logic             sck_prev;
    logic             ext_rise, ext_fall;
    logic             gen_rise, gen_fall;
    logic             rise_evt, fall_evt;
    logic             run_clk;
    logic             start_ok, load_ok, last_rise;
    logic [CNT_W-1:0] bit_cnt;
    logic             done_q, rdy_q;
    logic [WORD_W-1:0] sr;
    logic             sdo_q;

    sio_sync #(.W(3), .RST_VAL(3'b111)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sck_in, sdi, rdy_in}),
        .q     ({sck_s, sdi_s, rdy_s})
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sck_prev <= 1'b1;
        else        sck_prev <= sck_s;
    end

    sio_clkgen #(.DIV_W(DIV_W)) u_clkgen (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run_clk),
        .half   (half_div),
        .sck    (sck_out),
        .fall_p (gen_fall),
        .rise_p (gen_rise)
    );

    always_comb begin
        ext_rise  = !sck_prev && sck_s;
        ext_fall  = sck_prev && !sck_s;
        run_clk   = master_mode && (state == ST_SHIFT);
        rise_evt  = master_mode ? gen_rise : ext_rise;
        fall_evt  = master_mode ? gen_fall : ext_fall;
        start_ok  = (state == ST_IDLE) && start;
        load_ok   = (state == ST_IDLE) && wr_en;
        last_rise = (state == ST_SHIFT) && rise_evt && (bit_cnt == LAST_BIT);
    end

    sio_shifter #(.WORD_W(WORD_W)) u_shifter (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_ok),
        .load_val (wr_data),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt),
        .bit_in   (sdi_s),
        .sr       (sr),
        .sdo_q    (sdo_q)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (start) state_nx = master_mode ? ST_WAIT : ST_SHIFT;
            end
            ST_WAIT: begin
                if (!rdy_s) state_nx = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (rise_evt && (bit_cnt == LAST_BIT)) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // output process: bit counter, done flag, ready line
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            done_q  <= 1'b0;
            rdy_q   <= 1'b1;
        end else if (start_ok) begin
            bit_cnt <= '0;
            done_q  <= 1'b0;
            rdy_q   <= master_mode;
        end else if ((state == ST_SHIFT) && rise_evt) begin
            bit_cnt <= bit_cnt + CNT_W'(1);
            if (bit_cnt == LAST_BIT) begin
                done_q <= 1'b1;
                rdy_q  <= 1'b1;
            end
        end else if (done_clr) begin
            done_q <= 1'b0;
        end
    end

    assign rd_data = sr;
    assign done    = done_q;
    assign rdy_out = rdy_q;
    assign sdo     = sdo_q;

    // R2: the serial output moves only after a falling edge event
    assert_sdo_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdo) |-> $past(fall_evt));

    // R3: done rises only on the last counted rising edge of a transfer
    assert_done_after_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(last_rise));

    // R3: an accepted start leaves done cleared
    assert_start_clears_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        start_ok |=> !done);

    // R4: the generated clock rests high outside shifting
    assert_sck_idle_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_SHIFT) |-> sck_out);

    // R6: a master enters shifting only after seeing the partner ready
    assert_master_waits_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_WAIT && state == ST_SHIFT) |-> !$past(rdy_s));

    // R6: the ready line is low only for an armed slave
    assert_ready_only_armed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !rdy_out |-> (!master_mode && state == ST_SHIFT));

    // R7: writes during a transfer leave the register untouched
    assert_busy_write_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((state != ST_IDLE) && wr_en && !rise_evt) |=> $stable(sr));
endmodule

// File: tb/sio_unit_test.sv
`timescale 1ns/1ps
module sio_unit_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    // master side (uut)
    logic [7:0] m_half = 8'd8;
    logic       m_wr = 0, m_start = 0, m_clr = 0;
    logic [7:0] m_wdata = 0, m_rd;
    logic       m_done, m_sck, m_sdo, m_rdy;
    // slave side (peer)
    logic       p_wr = 0, p_start = 0, p_clr = 0;
    logic [7:0] p_wdata = 0, p_rd;
    logic       p_done, p_sck_out, p_sdo, p_rdy;
    // bench-driven external clock for the slave
    logic       ext_sel = 0, tb_sck = 1, tb_sdi = 0;
    logic       p_sck_in, p_sdi;

    assign p_sck_in = ext_sel ? tb_sck : m_sck;
    assign p_sdi    = ext_sel ? tb_sdi : m_sdo;

    sio_unit uut (
        .clk(clk), .rst_n(rst_n), .master_mode(1'b1), .half_div(m_half),
        .wr_en(m_wr), .wr_data(m_wdata), .rd_data(m_rd), .start(m_start),
        .done_clr(m_clr), .done(m_done), .sck_in(1'b1), .sck_out(m_sck),
        .sdi(p_sdo), .sdo(m_sdo), .rdy_in(p_rdy), .rdy_out(m_rdy)
    );

    sio_unit peer (
        .clk(clk), .rst_n(rst_n), .master_mode(1'b0), .half_div(8'd8),
        .wr_en(p_wr), .wr_data(p_wdata), .rd_data(p_rd), .start(p_start),
        .done_clr(p_clr), .done(p_done), .sck_in(p_sck_in), .sck_out(p_sck_out),
        .sdi(p_sdi), .sdo(p_sdo), .rdy_in(1'b1), .rdy_out(p_rdy)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Per-clock reference comparison: the master output may only move in the
    // cycle its shift clock falls, and its clock must rest high while no
    // transfer is open.
    logic prev_sdo = 1, prev_sck = 1;
    bit   mon_on = 0;
    bit   m_open = 0;
    int   mon_bad = 0;
    always @(negedge clk) begin
        cycles++;
        if (mon_on) begin
            if (m_sdo !== prev_sdo && !(prev_sck === 1'b1 && m_sck === 1'b0)) mon_bad++;
            if (!m_open && m_sck !== 1'b1) mon_bad++;
        end
        prev_sdo = m_sdo;
        prev_sck = m_sck;
    end

    // clock profile of the master during a transfer
    int lo_run, lo_min, lo_max, falls;
    task automatic run_master_transfer(output bit ok);
        int guard = 0;
        bit last_sck = 1;
        lo_run = 0; lo_min = 1000; lo_max = 0; falls = 0;
        m_open = 1;
        while (!m_done && guard < 5000) begin
            @(negedge clk);
            guard++;
            if (last_sck && !m_sck) falls++;
            if (!m_sck) lo_run++;
            if (!last_sck && m_sck) begin
                if (lo_run < lo_min) lo_min = lo_run;
                if (lo_run > lo_max) lo_max = lo_run;
                lo_run = 0;
            end
            last_sck = m_sck;
        end
        m_open = 0;
        ok = m_done;
    endtask

    task automatic pulse_start_m();
        m_start = 1; tick(1); m_start = 0;
    endtask
    task automatic pulse_start_p();
        p_start = 1; tick(1); p_start = 0;
    endtask

    // behavioural model of the slave register for bench-driven clocking
    logic [7:0] model;
    bit         in_q[$];

    task automatic ext_pulse(input bit b);
        logic exp_out;
        tb_sdi = b;
        tick(6);
        tb_sck = 0;
        exp_out = model[0];
        tick(6);
        check(p_sdo == exp_out, "R2 slave output on falling edge", p_sdo, exp_out);
        tb_sck = 1;
        model = {b, model[7:1]};
        tick(6);
    endtask

    initial begin
        while (cycles < 150000) @(negedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        bit ok;
        bit stayed_high;
        tick(3);
        rst_n = 1;
        tick(2);
        // R9 reset state
        check(m_done == 0 && p_done == 0, "R9 done after reset", m_done, 0);
        check(m_sck == 1 && m_sdo == 1, "R9 clock and output idle", {m_sck, m_sdo}, 3);
        check(p_rdy == 1 && m_rd == 8'h00, "R9 ready high, register zero", {p_rdy, m_rd}, 9'h100);
        mon_on = 1;

        // load both words; idle readback
        m_wdata = 8'hA5; m_wr = 1; p_wdata = 8'h3C; p_wr = 1; tick(1);
        m_wr = 0; p_wr = 0; tick(1);
        check(m_rd == 8'hA5, "R7 idle write readback", m_rd, 8'hA5);

        // master started while partner not ready: no clock
        pulse_start_m();
        stayed_high = 1;
        for (int i = 0; i < 60; i++) begin
            tick(1);
            if (m_sck !== 1'b1) stayed_high = 0;
        end
        check(stayed_high && !m_done, "R6 master held by high ready", m_sck, 1);

        // arm the slave; transfer proceeds
        pulse_start_p();
        tick(1);
        check(p_rdy == 0, "R6 slave ready low when armed", p_rdy, 0);
        run_master_transfer(ok);
        check(ok, "R3 master done after eight edges", m_done, 1);
        check(falls == 8 && lo_min == 8 && lo_max == 8, "R4 eight falls, low phase of half_div",
              falls * 256 + lo_min, 8 * 256 + 8);
        tick(12);
        check(m_rd == 8'h3C, "R1 master received word", m_rd, 8'h3C);
        check(p_rd == 8'hA5, "R1 slave received word", p_rd, 8'hA5);
        check(p_done == 1 && p_rdy == 1, "R6 slave done and ready high", {p_done, p_rdy}, 3);
        check(m_sck == 1 && m_sdo == 1, "R4 clock parked high, last bit held", {m_sck, m_sdo}, 3);

        // back-to-back transfer
        m_wdata = 8'h5A; m_wr = 1; p_wdata = 8'hC3; p_wr = 1; tick(1);
        m_wr = 0; p_wr = 0;
        pulse_start_p();
        pulse_start_m();
        check(m_done == 0, "R3 start clears done", m_done, 0);
        tick(2);
        check(m_sdo == 1, "R2 previous last bit held before first fall", m_sdo, 1);
        m_open = 1;
        tick(30);
        m_wdata = 8'hFF; m_wr = 1; tick(1); m_wr = 0;
        run_master_transfer(ok);
        tick(12);
        check(m_rd == 8'hC3, "R7 busy write ignored, R1 word", m_rd, 8'hC3);
        check(p_rd == 8'h5A, "R1 second slave word", p_rd, 8'h5A);

        // done clear
        m_clr = 1; p_clr = 1; tick(1); m_clr = 0; p_clr = 0;
        check(m_done == 0 && p_done == 0, "R8 done cleared", {m_done, p_done}, 0);

        // slave driven by bench clock
        ext_sel = 1;
        tick(4);
        p_wdata = 8'h96; p_wr = 1; tick(1); p_wr = 0;
        model = 8'h96;
        pulse_start_p();
        in_q = '{1, 0, 0, 1, 1, 1, 0, 1};
        for (int k = 0; k < 4; k++) ext_pulse(in_q[k]);
        check(p_rd == model && p_done == 0, "R7 partial read during transfer", p_rd, model);
        p_wdata = 8'h00; p_wr = 1; tick(1); p_wr = 0;
        tick(2);
        check(p_rd == model, "R7 slave busy write ignored", p_rd, model);
        for (int k = 4; k < 8; k++) ext_pulse(in_q[k]);
        tick(4);
        check(p_done == 1 && p_rdy == 1, "R3 slave done after eighth edge", {p_done, p_rdy}, 3);
        check(p_rd == 8'hB9, "R1 slave word from bench bits", p_rd, 8'hB9);
        ext_pulse(1'b0);
        ext_pulse(1'b1);
        tick(4);
        check(p_rd == model && p_done == 1, "R5 extra external edges still shift", p_rd, model);
        ext_sel = 0;
        tick(6);

        // clamped divider
        m_half = 8'd1;
        pulse_start_p();
        pulse_start_m();
        run_master_transfer(ok);
        check(ok && falls == 8 && lo_min == 2 && lo_max == 2, "R4 divider clamped to two",
              lo_max, 2);
        tick(4);

        check(mon_bad == 0, "R2 per-clock output and idle clock rule", mon_bad, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule